// File: doc/BRIEF.md
# Self-Clearing Dual-Domain Soft Reset Generator

This block lets software reset two clock domains on its own, without touching the chip-level reset. A write strobe with an 8-bit data word loads a 2-bit request field. Bit 0 asks for a reset of the primary domain. Bit 1 asks for a reset of the secondary domain. Setting both bits asks for both resets. Each request waits a fixed number of primary-clock cycles before it takes effect. The request bit then clears itself, so software never has to write a zero afterwards.

Each reset output is active low. It falls asynchronously as soon as its delayed request fires. It rises again only on an edge of its own domain's clock, after a minimum hold of several edges, so the logic it resets leaves reset cleanly in its own domain. The read port shows which requests are still waiting. The master reset input forces both outputs low and cancels every pending request.

Top module: `soft_reset_gen`

## Requirements
- R1: A write with `wr_data` bit 0 set pulses `pri_rst_n`, and a write with bit 1 set pulses `sec_rst_n`. An output whose bit is clear stays high.
- R2: Bits 7:2 of `wr_data` have no effect. Bits 7:2 of `rd_data` always read zero.
- R3: `rd_data[1:0]` is zero after master reset. From the cycle after a write, each bit written as 1 reads 1 until its request fires.
- R4: A requested output goes low right after the 7th rising `pri_clk` edge that follows the write edge, and never earlier.
- R5: A request bit reads back as 0 from the same edge at which its output goes low.
- R6: `pri_rst_n` rises only on a `pri_clk` edge. After a request it is low for exactly 5 `pri_clk` cycles, and always for at least 4.
- R7: `sec_rst_n` rises only on a `sec_clk` edge. It stays low for at least 4 `sec_clk` rising edges counted from its assertion, and releases by the 5th such edge when `sec_clk` is slower than `pri_clk`.
- R8: While `hard_rst_n` is low, both outputs are low and both request bits read 0. A request cancelled this way produces no later pulse. After `hard_rst_n` rises, each output rises on the 4th rising edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pri_clk | input | 1 | Primary clock; runs the request register and the delay pipeline |
| sec_clk | input | 1 | Secondary clock; releases the secondary reset |
| hard_rst_n | input | 1 | Master reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the request register, sampled on `pri_clk` |
| wr_data | input | 8 | Write data; bit 0 requests the primary reset, bit 1 the secondary reset |
| rd_data | output | 8 | Request bits still pending in bits 1:0; zeros above |
| pri_rst_n | output | 1 | Primary-domain reset, active low |
| sec_rst_n | output | 1 | Secondary-domain reset, active low |

## Verification
The bench keeps the default build: a 7-stage delay and a 4-flop release chain. It runs `sec_clk` at a period of 14 against 10 for `pri_clk`. With these clocks the secondary request sometimes lands between two `sec_clk` edges and sometimes not, so both possible release counts occur. An 8-bit write word has only 256 values, so the sweep writes every one of them. That covers every mix of request bits and reserved bits, and for each value the bench checks the exact assertion edge, the self-clearing and the release. A master reset pulled in the middle of a pending request shows that the request is cancelled and leaves no pulse behind.

// File: rtl/srg_pkg.sv
package srg_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned NUM_DOM = 2;

    typedef logic [NUM_DOM-1:0] dom_mask_t;

    typedef struct packed {
        dom_mask_t pending;
        dom_mask_t kick;
    } req_state_t;

    function automatic dom_mask_t req_field(input logic [REG_W-1:0] d);
        return d[NUM_DOM-1:0];
    endfunction

    function automatic logic [REG_W-1:0] status_word(input dom_mask_t p);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_DOM-1:0] = p;
        return w;
    endfunction

endpackage

// File: rtl/srg_request_tracker.sv
module srg_request_tracker
    import srg_pkg::*;
#(
    parameter int unsigned DELAY = 7
) (
    input  logic       clk,
    input  logic       hard_rst_n,
    input  logic       wr_en,
    input  dom_mask_t  wr_bits,
    output req_state_t state
);

    localparam int unsigned LAST = DELAY - 1;

    dom_mask_t pending_q;
    dom_mask_t kick_q;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        logic [DELAY-1:0] pipe_q;
        logic             set_req;
        logic             fire;

        assign set_req = wr_en & wr_bits[g];
        assign fire    = pipe_q[LAST];

        always_ff @(posedge clk or negedge hard_rst_n) begin
            if (!hard_rst_n) begin
                pipe_q       <= '0;
                pending_q[g] <= 1'b0;
                kick_q[g]    <= 1'b0;
            end else begin
                pipe_q       <= {pipe_q[DELAY-2:0], set_req};
                pending_q[g] <= (pending_q[g] & ~fire) | set_req;
                kick_q[g]    <= fire;
            end
        end
    end

    assign state.pending = pending_q;
    assign state.kick    = kick_q;

endmodule

// File: rtl/srg_release_cell.sv
module srg_release_cell #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic hard_rst_n,
    input  logic kick,
    output logic rst_out_n
);

    logic            cell_rst_n;
    logic [HOLD-1:0] chain_q;

    assign cell_rst_n = hard_rst_n & ~kick;

    always_ff @(posedge clk or negedge cell_rst_n) begin
        if (!cell_rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[HOLD-2:0], 1'b1};
        end
    end

    assign rst_out_n = chain_q[HOLD-1];

endmodule

// File: rtl/soft_reset_gen.sv
module soft_reset_gen
    import srg_pkg::*;
#(
    parameter int unsigned DELAY = 7,
    parameter int unsigned HOLD  = 4
) (
    input  logic             pri_clk,
    input  logic             sec_clk,
    input  logic             hard_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pri_rst_n,
    output logic             sec_rst_n
);

    req_state_t st;
    dom_mask_t  dom_clk;
    dom_mask_t  dom_rst_n;
    logic       reserved_unused;

    assign reserved_unused = ^wr_data[REG_W-1:NUM_DOM];
    assign dom_clk         = {sec_clk, pri_clk};

    srg_request_tracker #(.DELAY(DELAY)) u_track (
        .clk        (pri_clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (wr_en),
        .wr_bits    (req_field(wr_data)),
        .state      (st)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_rel
        srg_release_cell #(.HOLD(HOLD)) u_cell (
            .clk        (dom_clk[g]),
            .hard_rst_n (hard_rst_n),
            .kick       (st.kick[g]),
            .rst_out_n  (dom_rst_n[g])
        );
    end

    assign rd_data   = status_word(st.pending);
    assign pri_rst_n = dom_rst_n[0];
    assign sec_rst_n = dom_rst_n[1];

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
    parameter int unsigned HOLD = 4
) (
    input logic       pri_clk,
    input logic       sec_clk,
    input logic       hard_rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pri_rst_n,
    input logic       sec_rst_n
);

    logic [7:0] low_a_cnt;
    logic [7:0] low_b_cnt;

    always_ff @(posedge pri_clk or negedge hard_rst_n) begin
        if (!hard_rst_n)            low_a_cnt <= '0;
        else if (pri_rst_n)         low_a_cnt <= '0;
        else if (low_a_cnt != 8'hFF) low_a_cnt <= low_a_cnt + 8'd1;
    end

    always_ff @(posedge sec_clk or negedge hard_rst_n) begin
        if (!hard_rst_n)            low_b_cnt <= '0;
        else if (sec_rst_n)         low_b_cnt <= '0;
        else if (low_b_cnt != 8'hFF) low_b_cnt <= low_b_cnt + 8'd1;
    end

    // R2
    reserved_zero_chk: assert property (@(posedge pri_clk) disable iff (!hard_rst_n)
        rd_data[7:2] == 6'd0);

    // R3
    pending_set_chk: assert property (@(posedge pri_clk) disable iff (!hard_rst_n)
        wr_en |=> ((rd_data[1:0] & $past(wr_data[1:0])) == $past(wr_data[1:0])));

    // R5
    fire_after_pending_chk: assert property (@(posedge pri_clk) disable iff (!hard_rst_n)
        $fell(pri_rst_n) |-> $past(rd_data[0]));

    // R6
    pri_hold_chk: assert property (@(posedge pri_clk) disable iff (!hard_rst_n)
        $rose(pri_rst_n) |-> (low_a_cnt >= 8'(HOLD)));

    // R7
    sec_hold_chk: assert property (@(posedge sec_clk) disable iff (!hard_rst_n)
        $rose(sec_rst_n) |-> (low_b_cnt >= 8'(HOLD)));

    // R8
    master_low_chk: assert property (@(posedge pri_clk)
        !hard_rst_n |-> (!pri_rst_n && !sec_rst_n && rd_data == 8'd0));

endmodule

bind soft_reset_gen srg_checker #(.HOLD(HOLD)) u_srg_chk (
    .pri_clk    (pri_clk),
    .sec_clk    (sec_clk),
    .hard_rst_n (hard_rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pri_rst_n  (pri_rst_n),
    .sec_rst_n  (sec_rst_n)
);

// File: tb/tb_soft_reset_gen.sv
`timescale 1ns/1ps
module tb_soft_reset_gen;

    localparam int CLK_PERIOD  = 10;
    localparam int XCLK_PERIOD = 14;
    localparam int DELAY       = 7;
    localparam int HOLD        = 4;

    logic       pri_clk = 1'b0;
    logic       sec_clk = 1'b0;
    logic       hard_rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       pri_rst_n;
    logic       sec_rst_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2)  pri_clk = ~pri_clk;
    always #(XCLK_PERIOD/2) sec_clk = ~sec_clk;

    soft_reset_gen #(.DELAY(DELAY), .HOLD(HOLD)) dut (
        .pri_clk    (pri_clk),
        .sec_clk    (sec_clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .pri_rst_n  (pri_rst_n),
        .sec_rst_n  (sec_rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_req(input logic [7:0] d);
        @(negedge pri_clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge pri_clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        hard_rst_n = 1'b1;
        wr_en      = 1'b0;
        wr_data    = 8'h00;
        #2 hard_rst_n = 1'b0;
        repeat (3) @(negedge pri_clk);
        // R8 / R3: reset state
        chk("R8 pri low in reset", int'(pri_rst_n), 0);
        chk("R8 sec low in reset", int'(sec_rst_n), 0);
        chk("R3 pending zero in reset", int'(rd_data), 0);
        hard_rst_n = 1'b1;
        repeat (3) @(negedge pri_clk);
        chk("R8 pri still low on 3rd edge", int'(pri_rst_n), 0);
        @(negedge pri_clk);
        chk("R8 pri released on 4th edge", int'(pri_rst_n), 1);
        repeat (6) @(negedge pri_clk);
        chk("R8 sec released after master reset", int'(sec_rst_n), 1);

        // Sweep of every write word (R1, R2, R3, R4, R5, R6, R7)
        for (int v = 0; v < 256; v++) begin
            logic b0;
            logic b1;
            b0 = v[0];
            b1 = v[1];
            write_req(8'(v));
            chk("R3 pending after write", int'(rd_data), v & 3);
            chk("R2 reserved read zero", int'(rd_data[7:2]), 0);
            repeat (DELAY - 1) @(negedge pri_clk);
            chk("R4 pri not early", int'(pri_rst_n), 1);
            chk("R4 sec not early", int'(sec_rst_n), 1);
            chk("R3 pending held before fire", int'(rd_data), v & 3);
            @(negedge pri_clk);
            chk("R1 R4 pri asserted", int'(pri_rst_n), int'(!b0));
            chk("R1 R4 sec asserted", int'(sec_rst_n), int'(!b1));
            chk("R5 pending cleared at fire", int'(rd_data), 0);
            fork
                begin
                    repeat (HOLD) begin
                        @(negedge pri_clk);
                        chk("R6 pri held low", int'(pri_rst_n), int'(!b0));
                    end
                    @(negedge pri_clk);
                    chk("R6 pri released", int'(pri_rst_n), 1);
                end
                begin
                    if (b1) begin
                        int cnt;
                        cnt = 0;
                        for (int k = 0; k < 20; k++) begin
                            @(posedge sec_clk);
                            #1;
                            if (sec_rst_n) break;
                            cnt++;
                        end
                        chk("R7 sec released after edge", int'(sec_rst_n), 1);
                        chk("R7 sec edges at least hold", int'(cnt + 1 >= HOLD), 1);
                        chk("R7 sec edges at most hold+1", int'(cnt + 1 <= HOLD + 1), 1);
                    end
                end
            join
            repeat (3) @(negedge pri_clk);
            chk("R2 R1 both high after sequence", int'({pri_rst_n, sec_rst_n}), 3);
            chk("R5 no pending left", int'(rd_data), 0);
        end

        // R8: master reset cancels a pending request
        write_req(8'h03);
        repeat (2) @(negedge pri_clk);
        hard_rst_n = 1'b0;
        #1;
        chk("R8 pri low on master", int'(pri_rst_n), 0);
        chk("R8 sec low on master", int'(sec_rst_n), 0);
        chk("R8 pending cleared by master", int'(rd_data), 0);
        @(negedge pri_clk);
        hard_rst_n = 1'b1;
        repeat (HOLD) @(negedge pri_clk);
        chk("R8 pri back high", int'(pri_rst_n), 1);
        repeat (4) @(negedge pri_clk);
        chk("R8 sec back high", int'(sec_rst_n), 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge pri_clk);
            chk("R8 no stale pulse", int'({pri_rst_n, sec_rst_n, rd_data[1:0]}), 12);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule